// File: doc/BRIEF.md
# Register-Access Boot Sequencer

This block is a small microcoded engine that starts running when reset is released. It walks a program of fixed-length 32-bit instructions held in an internal ROM. Each instruction either touches one register in one of several peripheral register banks or changes the flow of the program. Typical banks are board control registers, an I2C master, a management-data master and an SPI master.

The program can store constants into registers and wait on a status field until it reaches a wanted value. It can also carry a value from one register to another through an 8-bit accumulator, jump, and halt. A typical program switches on the I2C master, loads its 16-bit clock prescaler as two bytes and issues a command. It then polls a busy bit and copies a sensor reading into a display register. All register traffic goes over one simple synchronous bus: a one-cycle access strobe with a bank code, register offset, write flag and write data, and read data returned by the bank. A done flag tells the rest of the chip that the program has stopped, and an error flag tells it that the stop came from an illegal instruction.

The ROM content is the parameter `PROG`, with instruction i at bits `[32*i +: 32]`.

Top module: `boot_seq_top`

## Requirements
- R1: Instruction word layout: bits [31:24] opcode, [23:21] bank code, [20:16] register offset, [15:8] argument A, [7:0] argument B. After reset execution starts at ROM address 0 with the accumulator at 0x00, and `done`, `err` and `bus_en` are low while reset is held.
- R2: Opcode 0x01 performs one write access to the addressed bank and register with argument A as the data, then continues with the next address.
- R3: A read access is a `bus_en` cycle with `bus_we` low. The bank returns data on `bus_rdata` in the cycle after the strobe cycle, and the sequencer samples it there.
- R4: Opcode 0x02 reads the register repeatedly until (read value AND argument A) equals argument B. No later instruction makes any access until the match occurs.
- R5: Opcode 0x03 loads the value read from the addressed register into the accumulator.
- R6: Opcode 0x04 writes the current accumulator value to the addressed register.
- R7: Opcode 0x05 sets the next instruction address to the low bits of argument A. Instructions jumped over make no access.
- R8: Opcode 0x00 raises `done`, leaves `err` low, and no further access happens until the next reset.
- R9: Any opcode from 0x06 to 0xFF stops execution like 0x00 but also raises `err`. Both flags hold until reset.
- R10: Every access strobe is exactly one cycle long: `bus_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the program |
| bus_en | output | 1 | One-cycle register access strobe |
| bus_we | output | 1 | High for a write access, low for a read |
| bus_sel | output | 3 | Bank code of the access |
| bus_addr | output | 5 | Register offset within the bank |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| done | output | 1 | Program has stopped |
| err | output | 1 | Program stopped on an illegal opcode |

## Verification
The main instance is built with a 16-entry ROM holding a program that uses every opcode. This makes the accumulator's reset value, the masked poll with an ignored status bit, a forward jump over a write, and the halt reachable in one run. A second instance with a 4-entry ROM puts an illegal opcode between two writes, which exposes the error stop and shows that the later write never happens. Reapplying reset after a finished run shows the program restarting from address 0 with a cleared accumulator.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int SEL_W   = 3;
  localparam int OFF_W   = 5;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 4 * BYTE_W;

  typedef enum logic [BYTE_W-1:0] {
    OP_END   = 8'h00,
    OP_WR    = 8'h01,
    OP_POLL  = 8'h02,
    OP_RDACC = 8'h03,
    OP_WRACC = 8'h04,
    OP_JMP   = 8'h05
  } opcode_e;

  typedef enum logic [2:0] {
    K_END, K_WR, K_POLL, K_RDACC, K_WRACC, K_JMP, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic [BYTE_W-1:0] arg_a;
    logic [BYTE_W-1:0] arg_b;
  } instr_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_ACCESS, ST_CAPTURE, ST_HALT
  } state_e;
endpackage

// File: rtl/bseq_rom.sv
module bseq_rom #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output instr_t             ins
);
  logic [BYTE_W-1:0] opc;

  always_comb begin
    opc       = word[4*BYTE_W-1 -: BYTE_W];
    ins.sel   = word[3*BYTE_W-1 -: SEL_W];
    ins.off   = word[3*BYTE_W-SEL_W-1 -: OFF_W];
    ins.arg_a = word[2*BYTE_W-1 -: BYTE_W];
    ins.arg_b = word[BYTE_W-1:0];
    case (opc)
      OP_END:   ins.kind = K_END;
      OP_WR:    ins.kind = K_WR;
      OP_POLL:  ins.kind = K_POLL;
      OP_RDACC: ins.kind = K_RDACC;
      OP_WRACC: ins.kind = K_WRACC;
      OP_JMP:   ins.kind = K_JMP;
      default:  ins.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int PC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  instr_t            ins,
  output logic [PC_W-1:0]   pc,
  output logic              bus_en,
  output logic              bus_we,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [OFF_W-1:0]  bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              done,
  output logic              err
);
  state_e            state;
  instr_t            cur;
  logic [BYTE_W-1:0] acc;
  logic              hit;

  assign hit = ((bus_rdata & cur.arg_a) == cur.arg_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= '0;
      acc       <= '0;
      cur       <= '0;
      bus_en    <= 1'b0;
      bus_we    <= 1'b0;
      bus_sel   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      bus_en <= 1'b0;
      bus_we <= 1'b0;
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          cur      <= ins;
          bus_sel  <= ins.sel;
          bus_addr <= ins.off;
          case (ins.kind)
            K_WR, K_WRACC: begin
              bus_en    <= 1'b1;
              bus_we    <= 1'b1;
              bus_wdata <= (ins.kind == K_WR) ? ins.arg_a : acc;
              pc        <= pc + 1'b1;
              state     <= ST_FETCH;
            end
            K_POLL, K_RDACC: begin
              bus_en <= 1'b1;
              state  <= ST_ACCESS;
            end
            K_JMP: begin
              pc    <= ins.arg_a[PC_W-1:0];
              state <= ST_FETCH;
            end
            K_END: begin
              done  <= 1'b1;
              state <= ST_HALT;
            end
            default: begin
              done  <= 1'b1;
              err   <= 1'b1;
              state <= ST_HALT;
            end
          endcase
        end
        ST_ACCESS: state <= ST_CAPTURE;
        ST_CAPTURE: begin
          if (cur.kind == K_RDACC) begin
            acc   <= bus_rdata;
            pc    <= pc + 1'b1;
            state <= ST_FETCH;
          end else if (hit) begin
            pc    <= pc + 1'b1;
            state <= ST_FETCH;
          end else begin
            bus_en <= 1'b1;
            state  <= ST_ACCESS;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import bseq_pkg::*;
#(
  parameter int ROM_DEPTH = 32,
  parameter logic [ROM_DEPTH*INSTR_W-1:0] PROG = '0,
  localparam int PC_W = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              bus_en,
  output logic              bus_we,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [OFF_W-1:0]  bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              done,
  output logic              err
);
  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] word;
  instr_t             ins;

  bseq_rom #(.DEPTH(ROM_DEPTH), .WIDTH(INSTR_W), .INIT(PROG)) u_rom (
    .clk(clk), .addr(pc), .q(word)
  );

  bseq_decode u_dec (.word(word), .ins(ins));

  bseq_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .ins(ins), .pc(pc),
    .bus_en(bus_en), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .err(err)
  );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk (
  input logic clk,
  input logic rst,
  input logic bus_en,
  input logic done,
  input logic err
);
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> !bus_en);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_en);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_err_has_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind boot_seq_top bseq_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .done(done), .err(err)
);

// File: tb/boot_seq_top_tb_top.sv
module boot_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_A = 16;
  localparam int DEPTH_B = 4;

  function automatic logic [31:0] ins(input logic [7:0] op, input logic [2:0] s,
                                      input logic [4:0] o, input logic [7:0] a,
                                      input logic [7:0] b);
    return {op, s, o, a, b};
  endfunction

  localparam logic [DEPTH_A*32-1:0] PROG_A = {
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    ins(8'h00, 3'd0, 5'd0,  8'h00, 8'h00),   // 9 end
    ins(8'h04, 3'd0, 5'd21, 8'h00, 8'h00),   // 8 acc -> display
    ins(8'h01, 3'd3, 5'd0,  8'hEE, 8'h00),   // 7 skipped
    ins(8'h05, 3'd0, 5'd0,  8'h08, 8'h00),   // 6 jump to 8
    ins(8'h03, 3'd2, 5'd7,  8'h00, 8'h00),   // 5 sensor -> acc
    ins(8'h02, 3'd1, 5'd4,  8'h01, 8'h00),   // 4 poll busy bit
    ins(8'h01, 3'd1, 5'd1,  8'h00, 8'h00),   // 3 prescaler high
    ins(8'h01, 3'd1, 5'd0,  8'h3F, 8'h00),   // 2 prescaler low
    ins(8'h01, 3'd1, 5'd2,  8'h80, 8'h00),   // 1 enable
    ins(8'h04, 3'd0, 5'd2,  8'h00, 8'h00)    // 0 acc -> reg
  };

  localparam logic [DEPTH_B*32-1:0] PROG_B = {
    32'h0,
    ins(8'h01, 3'd0, 5'd1, 8'h22, 8'h00),
    ins(8'h07, 3'd0, 5'd0, 8'h00, 8'h00),
    ins(8'h01, 3'd0, 5'd1, 8'h11, 8'h00)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b1;
  int   n_chk = 0;
  int   n_bad = 0;

  logic       bus_en, bus_we, done, err;
  logic [2:0] bus_sel;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       b_en, b_we, b_done, b_err;
  logic [2:0] b_sel;
  logic [4:0] b_addr;
  logic [7:0] b_wdata;

  logic [7:0] pmem [8][32];
  int         stat_reads;
  int         b_writes;
  logic [7:0] b_last;
  logic       prev_en;
  int         dbl_strobe;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_seq_top #(.ROM_DEPTH(DEPTH_A), .PROG(PROG_A)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .err(err)
  );

  boot_seq_top #(.ROM_DEPTH(DEPTH_B), .PROG(PROG_B)) dut_b (
    .clk(clk), .rst(rst), .bus_en(b_en), .bus_we(b_we), .bus_sel(b_sel),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(8'h00),
    .done(b_done), .err(b_err)
  );

  // peripheral bank model: registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 32; o++)
          pmem[s][o] <= (s == 2 && o == 7) ? 8'h5C : 8'hAA;
      bus_rdata  <= 8'h00;
      stat_reads <= 0;
      b_writes   <= 0;
      b_last     <= 8'h00;
      prev_en    <= 1'b0;
      dbl_strobe <= 0;
    end else begin
      prev_en <= bus_en;
      if (prev_en && bus_en) dbl_strobe <= dbl_strobe + 1;
      if (bus_en && bus_we) pmem[bus_sel][bus_addr] <= bus_wdata;
      if (bus_en && !bus_we) begin
        if (bus_sel == 3'd1 && bus_addr == 5'd4) begin
          bus_rdata  <= {7'b0100000, busy};
          stat_reads <= stat_reads + 1;
        end else begin
          bus_rdata <= pmem[bus_sel][bus_addr];
        end
      end
      if (b_en && b_we) begin
        b_writes <= b_writes + 1;
        b_last   <= b_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " done reached"}, done, 1'b1);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    wait_cycles(3);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 err in reset", err, 1'b0);
    chk("R1 bus_en in reset", bus_en, 1'b0);
  endtask

  task automatic t_poll_stall();
    int t = 0;
    busy = 1'b1;
    rst  = 1'b0;
    while (stat_reads < 4 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk("R4 repeated status reads", (stat_reads >= 4), 1'b1);
    chk("R2 enable write", pmem[1][2], 8'h80);
    chk("R2 prescaler low", pmem[1][0], 8'h3F);
    chk("R2 prescaler high", pmem[1][1], 8'h00);
    chk("R1 accumulator reset value written", pmem[0][2], 8'h00);
    wait_cycles(20);
    chk("R4 stalled: done low", done, 1'b0);
    chk("R4 stalled: no later access", pmem[0][21], 8'hAA);
    busy = 1'b0;
    wait_done("R4");
  endtask

  task automatic t_data_path();
    chk("R5 R6 R3 sensor copied through accumulator", pmem[0][21], 8'h5C);
    chk("R7 jumped-over write absent", pmem[3][0], 8'hAA);
  endtask

  task automatic t_end();
    chk("R8 err low on end", err, 1'b0);
    wait_cycles(30);
    chk("R8 bus quiet after end", pmem[3][0], 8'hAA);
    chk("R8 done held", done, 1'b1);
    chk("R10 no back-to-back strobes", dbl_strobe, 0);
  endtask

  task automatic t_illegal();
    chk("R9 done on illegal opcode", b_done, 1'b1);
    chk("R9 err on illegal opcode", b_err, 1'b1);
    chk("R9 only first write made", b_writes, 1);
    chk("R9 first write data", b_last, 8'h11);
  endtask

  task automatic t_restart();
    rst = 1'b1;
    wait_cycles(2);
    chk("R1 reg restored by model reset", pmem[0][2], 8'hAA);
    rst  = 1'b0;
    busy = 1'b0;
    wait_done("R1 restart");
    chk("R1 accumulator cleared by reset", pmem[0][2], 8'h00);
    chk("R5 second run copy", pmem[0][21], 8'h5C);
  endtask

  initial begin
    wait_cycles(100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_poll_stall();
    t_data_path();
    t_end();
    t_illegal();
    t_restart();
    finish_run();
  end
endmodule